// File: doc/BRIEF.md
# Indirect Configuration Table Access Controller

This block sits between a 32-bit register bus and a set of internal configuration tables: 32 scheme entries of 24 words each, and 64 port entries. Each port entry holds two words, a scheme-partition word and a classification-plan-partition word. The tables are too wide and too many to map directly, so the host never addresses them. Instead it works through a 24-word staging window and one action register.

To change an entry, the host fills the window and then writes the action register with its start bit set. The start bit names the direction, the target table, the entry number and which words take part. The block moves the data in a fixed number of cycles, clears the start bit and reports an error flag. A read works the same way in the other direction: the block copies the entry into the window, and the host then reads the window.

A global configuration register carries the enable for the datapath that uses the tables. An error event register records failed accesses.

Top module: `tbl_access_ctrl`

Register word indices (byte offset / 4): configuration 0x00 (byte 0x000), error event 0x03 (byte 0x00C), window 0x40..0x57 (bytes 0x100..0x15C), action 0x7F (byte 0x1FC).

## Requirements
- R1: After reset, the action, configuration, error event and window words all read 0, and `blk_enable` and `err_pending` are low.
- R2: Bit 31 of the configuration register is read/write and drives `blk_enable`. Its other bits read 0.
- R3: A write to the action register with bit 31 (start) set, while no access is running, starts an access. Bit 31 reads 1 during the 4 cycles that follow the write cycle and 0 afterwards. The other written fields read back as written, and bit 29 (error) reflects the result.
- R4: Action bits 25:24 = 00 select the scheme table, and the scheme number is in bits 23:16. With bit 30 clear (write), window words 0..23 are copied into the scheme. Word 16 is the packet-counter word, and it is copied only when bit 15 is set; otherwise the stored word 16 is kept.
- R5: A scheme access with bit 30 set (read) loads all 24 words of the scheme into the window.
- R6: Bits 25:24 = 10 select the port table, and the port number is in bits 7:0. Bit 15 moves the scheme-partition word, paired with window word 0. Bit 14 moves the classification-plan word, paired with window word 1. A word that is not selected is left unchanged, both in the table and in the window.
- R7: Bits 25:24 = 01 move only the classification-plan word of the port entry, whatever bits 15:14 hold.
- R8: An access completes with bit 29 set, and changes neither the tables nor the window, in any of these cases: the scheme number is 32 or more, the port number is 64 or more, or bits 25:24 = 11.
- R9: An access that ends in error sets bit 31 of the error event register and raises `err_pending`. Writing 1 to that bit clears it. An access that succeeds completes with bit 29 clear.
- R10: While an access is running, bus writes to the window and to the action register are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_waddr | input | 7 | Register word index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_waddr` (combinational) |
| blk_enable | output | 1 | Global enable from the configuration register |
| err_pending | output | 1 | Error event bit 31 |

## Verification
The bench sweeps every scheme and every port entry, writing and then reading back data it generates arithmetically. This catches index aliasing and word-lane swaps, which would show up as one entry overwriting another.

Scheme and port numbers just past the table ends are used to check that a design which truncates the index instead of rejecting it would corrupt entries 8 and 5. The bench checks that the counter word is kept when bit 15 is clear. It checks the single-word port selections and the classification-plan-only target, where a design that ignores the selection bits would clobber the sibling word. It also writes the window during an access; a design without that guard would commit the late data.

// File: rtl/itac_pkg.sv
package itac_pkg;

  localparam int DW = 32;

  // Register word indices on the host bus
  localparam logic [6:0] REG_GCR = 7'h00;
  localparam logic [6:0] REG_EER = 7'h03;
  localparam logic [6:0] REG_WIN = 7'h40;
  localparam logic [6:0] REG_ACT = 7'h7F;

  typedef enum logic [1:0] {
    TGT_SCHEME = 2'b00,
    TGT_CPLAN  = 2'b01,
    TGT_PORT   = 2'b10,
    TGT_BAD    = 2'b11
  } tgt_e;

  typedef struct packed {
    logic       go;
    logic       rd;
    logic       err;
    logic [2:0] pad_hi;
    tgt_e       tgt;
    logic [7:0] sch;
    logic       wsel_a;
    logic       wsel_b;
    logic [5:0] pad_lo;
    logic [7:0] port;
  } act_t;

endpackage

// File: rtl/itac_ram.sv
module itac_ram #(
  parameter int DW    = 32,
  parameter int DEPTH = 32,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem[addr] <= wdata;
    end
  end

  assign rdata = mem[addr];

endmodule

// File: rtl/itac_tables.sv
module itac_tables #(
  parameter int N_SCHEMES = 32,
  parameter int N_PORTS   = 64,
  parameter int WIN_WORDS = 24,
  localparam int SIDX_W   = $clog2(N_SCHEMES),
  localparam int PIDX_W   = $clog2(N_PORTS),
  localparam int WIN_W    = WIN_WORDS * 32
) (
  input  logic                 clk,
  input  logic [WIN_WORDS-1:0] sch_we,
  input  logic [SIDX_W-1:0]    sch_idx,
  input  logic [1:0]           prt_we,
  input  logic [PIDX_W-1:0]    prt_idx,
  input  logic [WIN_W-1:0]     wdata,
  output logic [WIN_W-1:0]     sch_rdata,
  output logic [63:0]          prt_rdata
);

  // One narrow RAM per scheme word lane
  for (genvar w = 0; w < WIN_WORDS; w++) begin : g_sch
    itac_ram #(.DW(32), .DEPTH(N_SCHEMES)) u_ram (
      .clk  (clk),
      .we   (sch_we[w]),
      .addr (sch_idx),
      .wdata(wdata[w*32 +: 32]),
      .rdata(sch_rdata[w*32 +: 32])
    );
  end

  // Lane 0: scheme partition, lane 1: classification plan partition
  for (genvar k = 0; k < 2; k++) begin : g_prt
    itac_ram #(.DW(32), .DEPTH(N_PORTS)) u_ram (
      .clk  (clk),
      .we   (prt_we[k]),
      .addr (prt_idx),
      .wdata(wdata[k*32 +: 32]),
      .rdata(prt_rdata[k*32 +: 32])
    );
  end

endmodule

// File: rtl/itac_window.sv
module itac_window #(
  parameter int WIN_WORDS = 24,
  localparam int WIDX_W   = $clog2(WIN_WORDS),
  localparam int WIN_W    = WIN_WORDS * 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_we,
  input  logic [WIDX_W-1:0]    bus_idx,
  input  logic [31:0]          bus_wdata,
  input  logic                 busy,
  input  logic [WIN_WORDS-1:0] ld,
  input  logic [WIN_W-1:0]     ld_data,
  output logic [WIN_W-1:0]     win_flat
);

  for (genvar w = 0; w < WIN_WORDS; w++) begin : g_word
    logic [31:0] q;
    logic [31:0] d;
    logic        en;

    always_comb begin
      en = 1'b0;
      d  = q;
      if (ld[w]) begin
        en = 1'b1;
        d  = ld_data[w*32 +: 32];
      end else if (bus_we && !busy && (bus_idx == WIDX_W'(w))) begin
        en = 1'b1;
        d  = bus_wdata;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q <= '0;
      end else if (en) begin
        q <= d;
      end
    end

    assign win_flat[w*32 +: 32] = q;
  end

endmodule

// File: rtl/itac_seq.sv
module itac_seq
  import itac_pkg::*;
#(
  parameter int N_SCHEMES  = 32,
  parameter int N_PORTS    = 64,
  parameter int WIN_WORDS  = 24,
  parameter int CNT_WORD   = 16,
  parameter int ACC_CYCLES = 4,
  localparam int SIDX_W    = $clog2(N_SCHEMES),
  localparam int PIDX_W    = $clog2(N_PORTS),
  localparam int CW        = (ACC_CYCLES > 1) ? $clog2(ACC_CYCLES) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 act_wr,
  input  logic [31:0]          wdata,
  output logic [31:0]          act_rd,
  output logic                 busy,
  output logic                 done,
  output logic                 acc_err,
  output logic [WIN_WORDS-1:0] sch_we,
  output logic [1:0]           prt_we,
  output logic [WIN_WORDS-1:0] win_ld,
  output logic                 ld_from_sch,
  output logic [SIDX_W-1:0]    sch_idx,
  output logic [PIDX_W-1:0]    prt_idx
);

  act_t          act_q, act_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          upd;
  logic          is_sch;
  logic [1:0]    psel;
  logic          ok;

  assign busy   = act_q.go;
  assign done   = busy && (cnt_q == '0);
  assign act_rd = act_q;
  assign is_sch = (act_q.tgt == TGT_SCHEME);
  assign sch_idx = act_q.sch[SIDX_W-1:0];
  assign prt_idx = act_q.port[PIDX_W-1:0];
  assign ld_from_sch = is_sch;

  // Range and target check on the latched command
  always_comb begin
    unique case (act_q.tgt)
      TGT_SCHEME: acc_err = (int'(act_q.sch) >= N_SCHEMES);
      TGT_PORT,
      TGT_CPLAN:  acc_err = (int'(act_q.port) >= N_PORTS);
      default:    acc_err = 1'b1;
    endcase
  end

  // Port word selection: [0] scheme partition, [1] class plan partition
  always_comb begin
    unique case (act_q.tgt)
      TGT_PORT:  psel = {act_q.wsel_b, act_q.wsel_a};
      TGT_CPLAN: psel = 2'b10;
      default:   psel = 2'b00;
    endcase
  end

  assign ok = done && !acc_err;

  for (genvar w = 0; w < WIN_WORDS; w++) begin : g_lane
    if (w == CNT_WORD) begin : g_cnt
      assign sch_we[w] = ok && is_sch && !act_q.rd && act_q.wsel_a;
    end else begin : g_plain
      assign sch_we[w] = ok && is_sch && !act_q.rd;
    end
    if (w < 2) begin : g_prt
      assign win_ld[w] = ok && act_q.rd && (is_sch || psel[w]);
    end else begin : g_sch_only
      assign win_ld[w] = ok && act_q.rd && is_sch;
    end
  end

  for (genvar k = 0; k < 2; k++) begin : g_pwe
    assign prt_we[k] = ok && !is_sch && !act_q.rd && psel[k];
  end

  // Next state
  always_comb begin
    act_d = act_q;
    cnt_d = cnt_q;
    upd   = 1'b0;
    if (busy) begin
      upd = 1'b1;
      if (cnt_q == '0) begin
        act_d.go  = 1'b0;
        act_d.err = acc_err;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end else if (act_wr) begin
      upd       = 1'b1;
      act_d     = act_t'(wdata);
      act_d.err = 1'b0;
      cnt_d     = CW'(ACC_CYCLES - 1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= '0;
      cnt_q <= '0;
    end else if (upd) begin
      act_q <= act_d;
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/tbl_access_ctrl.sv
module tbl_access_ctrl
  import itac_pkg::*;
#(
  parameter int N_SCHEMES  = 32,
  parameter int N_PORTS    = 64,
  parameter int WIN_WORDS  = 24,
  parameter int CNT_WORD   = 16,
  parameter int ACC_CYCLES = 4,
  localparam int WIDX_W    = $clog2(WIN_WORDS),
  localparam int SIDX_W    = $clog2(N_SCHEMES),
  localparam int PIDX_W    = $clog2(N_PORTS),
  localparam int WIN_W     = WIN_WORDS * 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_we,
  input  logic [6:0]  bus_waddr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        blk_enable,
  output logic        err_pending
);

  logic                 hit_win;
  logic [6:0]           woff;
  logic [WIDX_W-1:0]    win_idx;
  logic                 act_wr, gcr_wr, eer_wr, win_wr;
  logic [31:0]          act_rd;
  logic                 busy, done, acc_err, ld_from_sch;
  logic [WIN_WORDS-1:0] sch_we, win_ld;
  logic [1:0]           prt_we;
  logic [SIDX_W-1:0]    sch_idx;
  logic [PIDX_W-1:0]    prt_idx;
  logic [WIN_W-1:0]     win_flat, sch_rdata, ld_data;
  logic [63:0]          prt_rdata;
  logic                 gcr_q, gcr_d;
  logic                 eer_q, eer_d;

  // Bus decode
  assign woff    = bus_waddr - REG_WIN;
  assign hit_win = (bus_waddr >= REG_WIN) && (int'(woff) < WIN_WORDS);
  assign win_idx = woff[WIDX_W-1:0];
  assign act_wr  = bus_we && (bus_waddr == REG_ACT);
  assign gcr_wr  = bus_we && (bus_waddr == REG_GCR);
  assign eer_wr  = bus_we && (bus_waddr == REG_EER);
  assign win_wr  = bus_we && hit_win;

  itac_seq #(
    .N_SCHEMES (N_SCHEMES),
    .N_PORTS   (N_PORTS),
    .WIN_WORDS (WIN_WORDS),
    .CNT_WORD  (CNT_WORD),
    .ACC_CYCLES(ACC_CYCLES)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .act_wr     (act_wr),
    .wdata      (bus_wdata),
    .act_rd     (act_rd),
    .busy       (busy),
    .done       (done),
    .acc_err    (acc_err),
    .sch_we     (sch_we),
    .prt_we     (prt_we),
    .win_ld     (win_ld),
    .ld_from_sch(ld_from_sch),
    .sch_idx    (sch_idx),
    .prt_idx    (prt_idx)
  );

  itac_tables #(
    .N_SCHEMES(N_SCHEMES),
    .N_PORTS  (N_PORTS),
    .WIN_WORDS(WIN_WORDS)
  ) u_tables (
    .clk      (clk),
    .sch_we   (sch_we),
    .sch_idx  (sch_idx),
    .prt_we   (prt_we),
    .prt_idx  (prt_idx),
    .wdata    (win_flat),
    .sch_rdata(sch_rdata),
    .prt_rdata(prt_rdata)
  );

  // Load source for the window on a read access
  for (genvar w = 0; w < WIN_WORDS; w++) begin : g_ld
    if (w < 2) begin : g_both
      assign ld_data[w*32 +: 32] = ld_from_sch ? sch_rdata[w*32 +: 32]
                                               : prt_rdata[w*32 +: 32];
    end else begin : g_sch
      assign ld_data[w*32 +: 32] = sch_rdata[w*32 +: 32];
    end
  end

  itac_window #(.WIN_WORDS(WIN_WORDS)) u_win (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_we   (win_wr),
    .bus_idx  (win_idx),
    .bus_wdata(bus_wdata),
    .busy     (busy),
    .ld       (win_ld),
    .ld_data  (ld_data),
    .win_flat (win_flat)
  );

  // Global configuration and error event
  assign gcr_d = bus_wdata[31];
  assign eer_d = (done && acc_err) || (eer_q && !(eer_wr && bus_wdata[31]));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gcr_q <= 1'b0;
    end else if (gcr_wr) begin
      gcr_q <= gcr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eer_q <= 1'b0;
    end else begin
      eer_q <= eer_d;
    end
  end

  assign blk_enable  = gcr_q;
  assign err_pending = eer_q;

  // Read mux
  always_comb begin
    bus_rdata = '0;
    if (bus_waddr == REG_GCR) begin
      bus_rdata = {gcr_q, 31'b0};
    end else if (bus_waddr == REG_EER) begin
      bus_rdata = {eer_q, 31'b0};
    end else if (bus_waddr == REG_ACT) begin
      bus_rdata = act_rd;
    end else if (hit_win) begin
      bus_rdata = win_flat[win_idx*32 +: 32];
    end
  end

endmodule

// File: rtl/itac_chk.sv
module itac_chk #(
  parameter int WIN_WORDS  = 24,
  parameter int ACC_CYCLES = 4
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   busy,
  input logic                   done,
  input logic                   acc_err,
  input logic                   err_pending,
  input logic                   blk_enable,
  input logic                   gcr_wr,
  input logic                   wd31,
  input logic                   tbl_we_any,
  input logic [WIN_WORDS*32-1:0] win_flat
);

  logic [7:0] busy_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_cnt <= '0;
    end else if (!busy) begin
      busy_cnt <= '0;
    end else begin
      busy_cnt <= busy_cnt + 1'b1;
    end
  end

  // R3
  go_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (busy_cnt == 8'(ACC_CYCLES - 1)));

  // R3
  go_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);

  // R10
  win_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> $stable(win_flat));

  // R8
  err_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && acc_err) |-> !tbl_we_any);

  // R9
  err_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && acc_err) |=> err_pending);

  // R2
  en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gcr_wr |=> (blk_enable == $past(wd31)));

endmodule

bind tbl_access_ctrl itac_chk #(
  .WIN_WORDS (WIN_WORDS),
  .ACC_CYCLES(ACC_CYCLES)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .busy       (busy),
  .done       (done),
  .acc_err    (acc_err),
  .err_pending(err_pending),
  .blk_enable (blk_enable),
  .gcr_wr     (gcr_wr),
  .wd31       (bus_wdata[31]),
  .tbl_we_any ((|sch_we) || (|prt_we)),
  .win_flat   (win_flat)
);

// File: tb/tbl_access_ctrl_tb.sv
`timescale 1ns/1ps
module tbl_access_ctrl_tb;

  localparam logic [6:0] A_GCR = 7'h00;
  localparam logic [6:0] A_EER = 7'h03;
  localparam logic [6:0] A_WIN = 7'h40;
  localparam logic [6:0] A_ACT = 7'h7F;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [6:0]  bus_waddr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        blk_enable, err_pending;

  int n_chk = 0;
  int n_fail = 0;
  logic finished = 1'b0;

  always #2.5 clk = ~clk;

  tbl_access_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_waddr(bus_waddr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .blk_enable(blk_enable), .err_pending(err_pending)
  );

  function automatic logic [31:0] pat(input int s, input int w);
    return 32'h5C00_0000 | (32'(s) << 16) | (32'(w) << 8) | 32'((s * 7 + w) & 8'hFF);
  endfunction
  function automatic logic [31:0] spw(input int p);
    return 32'hA000_0000 | (32'(p) << 8) | 32'(p);
  endfunction
  function automatic logic [31:0] cpw(input int p);
    return 32'hC000_0000 | (32'(p) << 12) | 32'(p ^ 8'h3C);
  endfunction
  function automatic logic [31:0] a_sch(input bit rd, input int s, input bit cnt);
    return 32'h8000_0000 | (32'(rd) << 30) | (32'(s) << 16) | (32'(cnt) << 15);
  endfunction
  function automatic logic [31:0] a_prt(input bit rd, input int tgt, input int p,
                                        input bit sp, input bit cp);
    return 32'h8000_0000 | (32'(rd) << 30) | (32'(tgt) << 24) |
           (32'(sp) << 15) | (32'(cp) << 14) | 32'(p);
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic bw(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_waddr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic br(input logic [6:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_waddr = a;
    #1 d = bus_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    for (int i = 0; i < 40; i++) begin
      br(A_ACT, v);
      if (!v[31]) return;
    end
    chk("R3 access never completed", v, v & 32'h7FFF_FFFF);
  endtask

  task automatic access(input logic [31:0] a);
    bw(A_ACT, a);
    wait_idle();
  endtask

  logic [31:0] v;

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    br(A_ACT, v); chk("R1 action", v, 32'h0);
    br(A_GCR, v); chk("R1 gcr", v, 32'h0);
    br(A_EER, v); chk("R1 eer", v, 32'h0);
    br(A_WIN, v); chk("R1 window0", v, 32'h0);
    br(A_WIN + 7'd23, v); chk("R1 window23", v, 32'h0);
    chk("R1 blk_enable", 32'(blk_enable), 32'h0);
    chk("R1 err_pending", 32'(err_pending), 32'h0);

    // R2 enable register
    bw(A_GCR, 32'hFFFF_FFFF);
    br(A_GCR, v); chk("R2 gcr set", v, 32'h8000_0000);
    chk("R2 blk_enable high", 32'(blk_enable), 32'h1);
    bw(A_GCR, 32'h7FFF_FFFF);
    br(A_GCR, v); chk("R2 gcr clr", v, 32'h0);
    chk("R2 blk_enable low", 32'(blk_enable), 32'h0);

    // R4 write every scheme with counter update
    for (int s = 0; s < 32; s++) begin
      for (int w = 0; w < 24; w++) bw(A_WIN + 7'(w), pat(s, w));
      access(a_sch(0, s, 1));
    end
    // R5 read every scheme back
    for (int s = 0; s < 32; s++) begin
      access(a_sch(1, s, 0));
      for (int w = 0; w < 24; w++) begin
        br(A_WIN + 7'(w), v); chk("R5 scheme readback", v, pat(s, w));
      end
    end

    // R3 start-bit timing and field readback
    bw(A_ACT, a_sch(1, 5, 0));
    for (int i = 0; i < 4; i++) begin
      bus_waddr = A_ACT;
      #1 chk("R3 go high", 32'(bus_rdata[31]), 32'h1);
      @(negedge clk);
    end
    bus_waddr = A_ACT;
    #1 chk("R3 go low after 4", 32'(bus_rdata[31]), 32'h0);
    chk("R3 fields", bus_rdata, 32'h4005_0000);

    // R4 counter word kept when bit 15 clear
    for (int w = 0; w < 24; w++) bw(A_WIN + 7'(w), 32'hDEAD_0000 | 32'(w));
    access(a_sch(0, 3, 0));
    access(a_sch(1, 3, 0));
    br(A_WIN, v); chk("R4 word0 written", v, 32'hDEAD_0000);
    br(A_WIN + 7'd16, v); chk("R4 counter kept", v, pat(3, 16));
    br(A_WIN + 7'd23, v); chk("R4 word23 written", v, 32'hDEAD_0017);

    // R6 write every port entry, both words
    for (int p = 0; p < 64; p++) begin
      bw(A_WIN, spw(p)); bw(A_WIN + 7'd1, cpw(p));
      access(a_prt(0, 2, p, 1, 1));
    end
    for (int p = 0; p < 64; p++) begin
      bw(A_WIN, 32'h0); bw(A_WIN + 7'd1, 32'h0);
      access(a_prt(1, 2, p, 1, 1));
      br(A_WIN, v); chk("R6 sp readback", v, spw(p));
      br(A_WIN + 7'd1, v); chk("R6 cpp readback", v, cpw(p));
    end

    // R6 single word selections
    bw(A_WIN, 32'h1111_1111); bw(A_WIN + 7'd1, 32'h2222_2222);
    access(a_prt(0, 2, 7, 1, 0));
    access(a_prt(1, 2, 7, 1, 1));
    br(A_WIN, v); chk("R6 sp-only written", v, 32'h1111_1111);
    br(A_WIN + 7'd1, v); chk("R6 cpp untouched", v, cpw(7));
    bw(A_WIN, 32'hAAAA_0000);
    access(a_prt(1, 2, 7, 0, 1));
    br(A_WIN, v); chk("R6 window0 untouched", v, 32'hAAAA_0000);
    br(A_WIN + 7'd1, v); chk("R6 cpp-only read", v, cpw(7));

    // R7 classification plan target
    bw(A_WIN, 32'h7777_0002); bw(A_WIN + 7'd1, 32'h7777_0001);
    access(a_prt(0, 1, 9, 0, 0));
    access(a_prt(1, 2, 9, 1, 1));
    br(A_WIN, v); chk("R7 sp untouched", v, spw(9));
    br(A_WIN + 7'd1, v); chk("R7 cpp written", v, 32'h7777_0001);
    bw(A_WIN, 32'h0BAD_0BAD); bw(A_WIN + 7'd1, 32'h0);
    access(a_prt(1, 1, 9, 1, 1));
    br(A_WIN, v); chk("R7 window0 untouched", v, 32'h0BAD_0BAD);
    br(A_WIN + 7'd1, v); chk("R7 cpp read", v, 32'h7777_0001);

    // R8 / R9 out-of-range scheme
    chk("R9 no pending before", 32'(err_pending), 32'h0);
    for (int w = 0; w < 24; w++) bw(A_WIN + 7'(w), 32'hEEEE_EEEE);
    access(a_sch(0, 40, 1));
    br(A_ACT, v); chk("R8 scheme range err bit", 32'(v[29]), 32'h1);
    br(A_EER, v); chk("R9 eer set", v, 32'h8000_0000);
    chk("R9 err_pending", 32'(err_pending), 32'h1);
    access(a_sch(1, 8, 0));
    br(A_ACT, v); chk("R9 ok clears err bit", 32'(v[29]), 32'h0);
    br(A_WIN, v); chk("R8 scheme 8 intact", v, pat(8, 0));
    bw(A_EER, 32'h8000_0000);
    br(A_EER, v); chk("R9 eer cleared", v, 32'h0);
    chk("R9 err_pending cleared", 32'(err_pending), 32'h0);

    // R8 out-of-range port, bad target, errored read
    bw(A_WIN, 32'hEEEE_0001);
    access(a_prt(0, 2, 69, 1, 1));
    br(A_ACT, v); chk("R8 port range err bit", 32'(v[29]), 32'h1);
    access(a_prt(1, 2, 5, 1, 1));
    br(A_WIN, v); chk("R8 port 5 intact", v, spw(5));
    access(a_prt(0, 3, 2, 1, 1));
    br(A_ACT, v); chk("R8 bad target err bit", 32'(v[29]), 32'h1);
    bw(A_WIN, 32'h5EE0_5EE0);
    access(a_sch(1, 33, 0));
    br(A_ACT, v); chk("R8 read range err bit", 32'(v[29]), 32'h1);
    br(A_WIN, v); chk("R8 window untouched on err", v, 32'h5EE0_5EE0);
    bw(A_EER, 32'h8000_0000);

    // R10 writes ignored during an access
    for (int w = 0; w < 24; w++) bw(A_WIN + 7'(w), pat(9, w) ^ 32'h0F0F_0F0F);
    bw(A_ACT, a_sch(0, 9, 1));
    bw(A_WIN, 32'hBADB_AD00);
    bw(A_ACT, a_sch(1, 2, 0));
    wait_idle();
    br(A_ACT, v); chk("R10 action write ignored", v, 32'h0009_8000);
    br(A_WIN, v); chk("R10 window write ignored", v, pat(9, 0) ^ 32'h0F0F_0F0F);
    bw(A_WIN, 32'h0);
    access(a_sch(1, 9, 0));
    br(A_WIN, v); chk("R10 scheme got old window", v, pat(9, 0) ^ 32'h0F0F_0F0F);

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule